// File: doc/BRIEF.md
# Masked Trigger Combiner with Veto and Delayed Output Pulse

The block turns a bank of asynchronous comparator outputs into one accepted trigger for a detector readout system. Each channel input is brought into the sample clock domain and reduced to a single-cycle event on its rising edge. Every trigger source has its own channel mask that decides which channels feed it. A select field then decides which sources are ORed into the combined trigger, and a veto input, resynchronised with the same latency as the channels, overrides all of them.

When a trigger is accepted the block raises a sample interrupt towards the microcontroller. In the same cycle it captures the identifier word that the external timing unit presents synchronously. It then drives an active-high output pulse whose start delay and length are counted in sample-clock cycles. No further trigger is accepted until the pulse has ended and the microcontroller has acknowledged the interrupt. All settings are written, and the captured identifier and status are read, through a flat register port.

Top module: `trigCombiner`

## Requirements
- R1: After reset trigOut and sampleIrq are low, the identifier register reads 0 and the status register reads 0.
- R2: A channel that rises and stays high yields one event only. It cannot cause a second acceptance until it has gone low and risen again.
- R3: A channel counts towards source s only when its bit is set in that source's mask (address s). A source counts only when its bit in the select register (address 8, bit s) is set.
- R4: While the veto input, sampled at the same edge as the channel rise, is high, an event is not accepted.
- R5: sampleIrq rises on the third rising edge at which a channel is sampled high. trigOut rises D cycles after sampleIrq rises and stays high for W cycles, where D is the delay register (address 9) and W is the width register (address 10).
- R6: A width of zero gives a trigOut pulse of exactly one cycle.
- R7: sampleIrq stays high until irqAck is sampled high, and it goes low on that edge.
- R8: The identifier register (address 11) takes the value of tluId at the edge where sampleIrq rises and holds it at all other times.
- R9: No new trigger is accepted while the output pulse is pending or running, or while sampleIrq is high.
- R10: Configuration registers read back the value written. The status register (address 12) shows the interrupt in bit 0 and the pending or running pulse in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chIn | input | NUM_CH | Asynchronous comparator channel inputs |
| vetoIn | input | 1 | Asynchronous veto, active high |
| tluId | input | ID_W | Trigger identifier from the timing unit, synchronous to clk |
| irqAck | input | 1 | Interrupt acknowledge strobe |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 4 | Register write address |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | 4 | Register read address |
| rdData | output | DATA_W | Register read data, combinational from rdAddr |
| trigOut | output | 1 | Delayed, stretched trigger output |
| sampleIrq | output | 1 | Sample interrupt to the microcontroller |

## Verification
The assertions assume that irqAck, tluId and the register port are synchronous to the sample clock. They also assume that the veto reaches the accept logic through the same two-stage delay as the channels, so a veto and a channel edge that appear at the same edge meet in the same cycle. The stimulus changes every input a quarter period after the rising edge. It holds acknowledges and channel pulses for exactly one sampled edge, except in the scenario that deliberately holds a channel high. It moves the identifier on every cycle, so a capture at the wrong edge shows up as a wrong value.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_SELECT = 4'd8;
  localparam logic [ADDR_W-1:0] A_DELAY  = 4'd9;
  localparam logic [ADDR_W-1:0] A_WIDTH  = 4'd10;
  localparam logic [ADDR_W-1:0] A_ID     = 4'd11;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd12;

  typedef struct packed {
    logic latchId;  // capture tluId this cycle
    logic irq;      // interrupt pending
    logic busy;     // pulse pending or running
  } ctlStrobes_t;
endpackage

// File: rtl/trigDatapath.sv
module trigDatapath
  import trig_pkg::*;
#(
  parameter int NUM_CH  = 24,
  parameter int NUM_SRC = 3,
  parameter int CNT_W   = 16,
  parameter int ID_W    = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chIn,
  input  logic              vetoIn,
  input  logic [ID_W-1:0]   tluId,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  ctlStrobes_t       strobes,
  output logic              srcHit,
  output logic              vetoSync,
  output logic [CNT_W-1:0]  delayCfg,
  output logic [CNT_W-1:0]  widthCfg,
  output logic [ID_W-1:0]   idHold
);
  logic [NUM_CH-1:0] syncA, syncB, prevB, chEvent;
  logic              vetoA;
  logic [NUM_CH-1:0] srcMask [NUM_SRC];
  logic [NUM_SRC-1:0] srcSel, srcActive;
  logic              unusedWr;

  assign unusedWr = ^wrData;

  // two-stage synchronisers plus edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0; syncB <= '0; prevB <= '0;
      vetoA <= 1'b0; vetoSync <= 1'b0;
    end else begin
      syncA <= chIn; syncB <= syncA; prevB <= syncB;
      vetoA <= vetoIn; vetoSync <= vetoA;
    end
  end

  assign chEvent = syncB & ~prevB;

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) srcMask[s] <= '0;
        else if (wrEn && wrAddr == ADDR_W'(s)) srcMask[s] <= wrData[NUM_CH-1:0];
      end
      assign srcActive[s] = srcSel[s] & (|(chEvent & srcMask[s]));
    end
  endgenerate

  assign srcHit = |srcActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel <= '0; delayCfg <= '0; widthCfg <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_SELECT: srcSel   <= wrData[NUM_SRC-1:0];
        A_DELAY:  delayCfg <= wrData[CNT_W-1:0];
        A_WIDTH:  widthCfg <= wrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idHold <= '0;
    else if (strobes.latchId) idHold <= tluId;
  end

  always_comb begin
    rdData = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (rdAddr == ADDR_W'(s)) rdData = DATA_W'(srcMask[s]);
    case (rdAddr)
      A_SELECT: rdData = DATA_W'(srcSel);
      A_DELAY:  rdData = DATA_W'(delayCfg);
      A_WIDTH:  rdData = DATA_W'(widthCfg);
      A_ID:     rdData = DATA_W'(idHold);
      A_STATUS: rdData = DATA_W'({strobes.busy, strobes.irq});
      default: ;
    endcase
  end
endmodule

// File: rtl/trigControl.sv
module trigControl
  import trig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcHit,
  input  logic             vetoSync,
  input  logic             irqAck,
  input  logic [CNT_W-1:0] delayCfg,
  input  logic [CNT_W-1:0] widthCfg,
  output ctlStrobes_t      strobes,
  output logic             trigOut,
  output logic             sampleIrq
);
  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_PULSE} phase_t;
  phase_t          phase;
  logic [CNT_W-1:0] cnt, widthLast;
  logic             accept;

  assign accept    = (phase == ST_IDLE) && !sampleIrq && srcHit && !vetoSync;
  assign widthLast = (widthCfg == '0) ? '0 : widthCfg - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        ST_IDLE: if (accept) begin
          if (delayCfg == '0) begin phase <= ST_PULSE; cnt <= widthLast; end
          else begin phase <= ST_DELAY; cnt <= delayCfg - CNT_W'(1); end
        end
        ST_DELAY: if (cnt == '0) begin phase <= ST_PULSE; cnt <= widthLast; end
                  else cnt <= cnt - CNT_W'(1);
        ST_PULSE: if (cnt == '0) phase <= ST_IDLE;
                  else cnt <= cnt - CNT_W'(1);
        default: phase <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampleIrq <= 1'b0;
    else if (accept) sampleIrq <= 1'b1;
    else if (irqAck) sampleIrq <= 1'b0;
  end

  assign trigOut         = (phase == ST_PULSE);
  assign strobes.latchId = accept;
  assign strobes.irq     = sampleIrq;
  assign strobes.busy    = (phase != ST_IDLE);
endmodule

// File: rtl/trigCombiner.sv
module trigCombiner
  import trig_pkg::*;
#(
  parameter int NUM_CH  = 24,
  parameter int NUM_SRC = 3,
  parameter int CNT_W   = 16,
  parameter int ID_W    = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chIn,
  input  logic              vetoIn,
  input  logic [ID_W-1:0]   tluId,
  input  logic              irqAck,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              trigOut,
  output logic              sampleIrq
);
  ctlStrobes_t      strobes;
  logic             srcHit, vetoSync, busy;
  logic [CNT_W-1:0] delayCfg, widthCfg;
  logic [ID_W-1:0]  idHold;

  assign busy = strobes.busy;

  trigDatapath #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .CNT_W(CNT_W),
                 .ID_W(ID_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .chIn(chIn), .vetoIn(vetoIn), .tluId(tluId),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .strobes(strobes), .srcHit(srcHit),
    .vetoSync(vetoSync), .delayCfg(delayCfg), .widthCfg(widthCfg),
    .idHold(idHold));

  trigControl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .srcHit(srcHit), .vetoSync(vetoSync),
    .irqAck(irqAck), .delayCfg(delayCfg), .widthCfg(widthCfg),
    .strobes(strobes), .trigOut(trigOut), .sampleIrq(sampleIrq));
endmodule

// File: rtl/trigCombiner_chk.sv
module trigCombiner_chk #(
  parameter int ID_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            sampleIrq,
  input logic            irqAck,
  input logic            vetoSync,
  input logic            busy,
  input logic [ID_W-1:0] idHold
);
  // R4: an acceptance never happens in a cycle where the synchronised veto was high
  a_r4_veto_priority: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleIrq) |-> !$past(vetoSync));

  // R7: interrupt held until acknowledged
  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rstN)
    (sampleIrq && !irqAck) |=> sampleIrq);

  // R7: acknowledge clears the interrupt
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (sampleIrq && irqAck) |=> !sampleIrq);

  // R8: identifier only changes when the interrupt rises
  a_r8_id_stable: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(sampleIrq) |-> $stable(idHold));

  // R9: acceptance only from the idle phase
  a_r9_lockout: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleIrq) |-> !$past(busy));
endmodule

bind trigCombiner trigCombiner_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleIrq(sampleIrq), .irqAck(irqAck),
  .vetoSync(vetoSync), .busy(busy), .idHold(idHold));

// File: tb/sim_trigCombiner.sv
module sim_trigCombiner;
  localparam int NCH = 24;
  localparam int NSRC = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NCH-1:0] chIn = '0;
  logic vetoIn = 1'b0, irqAck = 1'b0, wrEn = 1'b0;
  logic [15:0] tluId = 16'h1234;
  logic [3:0] wrAddr = '0, rdAddr = 4'd11;
  logic [31:0] wrData = '0, rdData;
  logic trigOut, sampleIrq;

  int total = 0, bad = 0;
  bit finished = 0;

  trigCombiner u0 (.clk(clk), .rstN(rstN), .chIn(chIn), .vetoIn(vetoIn),
    .tluId(tluId), .irqAck(irqAck), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .trigOut(trigOut),
    .sampleIrq(sampleIrq));

  always #10 clk = ~clk;

  always @(posedge clk) begin #5; tluId = tluId + 16'd37; end

  // reference model
  logic [NCH-1:0] chHist[$];
  bit vetoHist[$];
  logic [NCH-1:0] mMask [NSRC];
  logic [NSRC-1:0] mSel;
  longint cyc, pStart, pEnd, mDelay, mWidth;
  bit mIrq, expOut;
  logic [15:0] mId;

  task automatic modelReset();
    chHist = {'0, '0, '0, '0};
    vetoHist = {0, 0, 0, 0};
    for (int s = 0; s < NSRC; s++) mMask[s] = '0;
    mSel = '0; cyc = 0; pStart = 0; pEnd = 0; mDelay = 0; mWidth = 0;
    mIrq = 0; expOut = 0; mId = '0;
  endtask

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      logic [NCH-1:0] ev;
      bit hit, acc;
      ev = chHist[1] & ~chHist[2];
      hit = 0;
      for (int s = 0; s < NSRC; s++) if (mSel[s] && (ev & mMask[s]) != '0) hit = 1;
      acc = (cyc >= pEnd) && !mIrq && hit && !vetoHist[1];
      if (acc) begin
        pStart = cyc + mDelay;
        pEnd = pStart + ((mWidth == 0) ? 1 : mWidth);
        mIrq = 1; mId = tluId;
      end else if (irqAck && mIrq) mIrq = 0;
      expOut = (cyc >= pStart) && (cyc < pEnd);
      chHist.push_front(chIn); void'(chHist.pop_back());
      vetoHist.push_front(vetoIn); void'(vetoHist.pop_back());
      if (wrEn) begin
        if (wrAddr < NSRC) mMask[wrAddr] = wrData[NCH-1:0];
        if (wrAddr == 4'd8) mSel = wrData[NSRC-1:0];
        if (wrAddr == 4'd9) mDelay = wrData[15:0];
        if (wrAddr == 4'd10) mWidth = wrData[15:0];
      end
      cyc++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rstN && !finished) begin
    chk("R5 trigOut", 32'(trigOut), 32'(expOut));
    chk("R7 sampleIrq", 32'(sampleIrq), 32'(mIrq));
    if (rdAddr == 4'd11) chk("R8 id", rdData, 32'(mId));
  end

  task automatic tick(); @(posedge clk); #5; endtask
  task automatic waitN(int n); repeat (n) tick(); endtask
  task automatic wrReg(logic [3:0] a, logic [31:0] d);
    tick(); wrEn = 1; wrAddr = a; wrData = d; tick(); wrEn = 0;
  endtask
  task automatic rdReg(logic [3:0] a, output logic [31:0] d);
    tick(); rdAddr = a; #6; d = rdData; tick(); rdAddr = 4'd11;
  endtask
  task automatic pulseCh(int ch);
    tick(); chIn[ch] = 1; tick(); chIn[ch] = 0;
  endtask
  task automatic ack(); tick(); irqAck = 1; tick(); irqAck = 0; endtask

  task automatic finishRun();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    int cnt;
    repeat (3) @(posedge clk);
    #5;
    chk("R1 trigOut at reset", 32'(trigOut), 0);
    chk("R1 irq at reset", 32'(sampleIrq), 0);
    rstN = 1;
    rdReg(4'd11, d); chk("R1 id after reset", d, 0);
    rdReg(4'd12, d); chk("R1 status after reset", d, 0);

    wrReg(4'd0, 32'h0000FF); wrReg(4'd1, 32'h00FF00); wrReg(4'd2, 32'hFF0000);
    wrReg(4'd8, 32'h1); wrReg(4'd9, 32'd3); wrReg(4'd10, 32'd4);
    rdReg(4'd1, d); chk("R10 mask1 readback", d, 32'h00FF00);
    rdReg(4'd9, d); chk("R10 delay readback", d, 3);

    // R3: unselected source ignored, selected source accepted
    pulseCh(10); waitN(8); chk("R3 unselected source", 32'(sampleIrq), 0);
    pulseCh(2); waitN(2); chk("R3 selected source", 32'(sampleIrq), 1);
    rdReg(4'd12, d); chk("R10 status irq+busy", d, 3);
    // R9: event while interrupt pending is dropped
    waitN(12); pulseCh(4); waitN(4);
    chk("R7 irq held", 32'(sampleIrq), 1);
    ack(); waitN(6); chk("R9 no accept while irq pending", 32'(sampleIrq), 0);

    // R2: held-high channel gives one event
    tick(); chIn[3] = 1; waitN(4); chk("R2 first edge", 32'(sampleIrq), 1);
    waitN(10); ack(); waitN(10);
    chk("R2 held level no retrigger", 32'(sampleIrq), 0);
    tick(); chIn[3] = 0; waitN(4);

    // R4: veto blocks, then release allows
    tick(); vetoIn = 1; chIn[1] = 1; tick(); chIn[1] = 0; vetoIn = 0;
    waitN(8); chk("R4 veto blocks", 32'(sampleIrq), 0);
    pulseCh(1); waitN(2); chk("R4 accepted after veto", 32'(sampleIrq), 1);
    waitN(10); ack(); waitN(3);

    // R6: zero width, zero delay -> single cycle
    wrReg(4'd9, 0); wrReg(4'd10, 0);
    cnt = 0;
    pulseCh(5);
    for (int i = 0; i < 10; i++) begin tick(); #6; if (trigOut) cnt++; end
    chk("R6 one-cycle pulse", cnt, 1);
    ack(); waitN(3);

    // R9: busy lockout during a long pulse, even after ack
    wrReg(4'd10, 50);
    pulseCh(6); waitN(3); ack(); waitN(3);
    rdReg(4'd12, d); chk("R10 status busy only", d, 2);
    pulseCh(7); waitN(8); chk("R9 no accept while busy", 32'(sampleIrq), 0);
    waitN(50);

    // R3: remapped masks and multiple selected sources
    wrReg(4'd1, 32'h000004); wrReg(4'd8, 32'h6); wrReg(4'd9, 2); wrReg(4'd10, 3);
    pulseCh(0); waitN(8); chk("R3 deselected source 0", 32'(sampleIrq), 0);
    pulseCh(2); waitN(2); chk("R3 remapped source 1", 32'(sampleIrq), 1);
    waitN(8); ack(); waitN(3);
    pulseCh(17); waitN(2); chk("R3 source 2 selected", 32'(sampleIrq), 1);
    rdReg(4'd11, d); chk("R8 id readback", d, 32'(mId));
    waitN(8); ack(); waitN(5);
    finishRun();
  end
endmodule